// File: doc/BRIEF.md
# Converter Output Formatter with Alternating Test Patterns

This block is the digital output stage of a 6-bit converter that also has an overflow flag. Each clock, the conversion core presents a raw 6-bit code and an overflow bit. The block registers them in a capture stage and then in an output latch, so a sample appears at the outputs two clocks after it is presented. On its way into the output latch, the code is recoded according to two static control inputs. One input flips the top data bit and the other flips the five lower data bits. Together they select straight binary, inverted binary, two's complement or inverted two's complement.

A synchronous test input takes over the output latch only. While it is high, the 7-bit word alternates between 1010101 and 0101010 on every clock, starting with 1010101 at the first edge. The capture stage keeps accepting samples during test mode, so valid data resumes on the first edge after the test input falls. A data-ready strobe toggles with every output word, and a second output always carries its inverse.

Top module: `adc_out_fmt`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the next outputs are `data_o` = 0000000, `dready_o` = 0 and `dready_n_o` = 1.
- R2: In normal mode, a sample presented on `code_i`/`ovf_i` before clock edge k appears on `data_o` after edge k+1 (two registers of delay).
- R3: With `msb_inv_i`=0 and `lsb_inv_i`=0, `data_o[5:0]` equals the code unchanged (straight binary: code 0 reads 000000, code 63 reads 111111).
- R4: With both inversion inputs at 1, `data_o[5:0]` is the bitwise complement of the code (code 0 reads 111111).
- R5: With `msb_inv_i`=1 and `lsb_inv_i`=0, only bit 5 is complemented (two's complement: code 0 reads 100000, code 32 reads 000000).
- R6: With `msb_inv_i`=0 and `lsb_inv_i`=1, bits 4..0 are complemented and bit 5 passes (code 0 reads 011111).
- R7: In normal mode, `data_o[6]` equals the overflow bit of the same sample, whatever the inversion inputs are.
- R8: At the first clock edge where `test_i` is 1 after a clock edge where it was 0 (or after reset), `data_o` becomes 1010101 (bit 6 first).
- R9: At each later edge with `test_i` still 1, `data_o` switches between 1010101 and 0101010.
- R10: At the first edge where `test_i` is 0 again, `data_o` shows the formatted sample that was presented one edge earlier. The capture stage is not stalled during test mode.
- R11: After reset, `dready_o` toggles at every clock edge, and `dready_n_o` is always its complement.
- R12: Each new entry into test mode starts again at 1010101, whatever phase the previous test run ended in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code_i | input | 6 | Raw conversion code from the core |
| ovf_i | input | 1 | Overflow flag from the core |
| msb_inv_i | input | 1 | Complements data bit 5 when high |
| lsb_inv_i | input | 1 | Complements data bits 4..0 when high |
| test_i | input | 1 | Selects the alternating test patterns |
| data_o | output | 7 | Output word; bit 6 is overflow |
| dready_o | output | 1 | Data-ready strobe, toggles per word |
| dready_n_o | output | 1 | Complement of dready_o |

## Verification
The hardest case to reach is the clock of exit from test mode. At that edge the output must carry a sample that was captured while the test patterns were still being shown. The stimulus ramps the code and toggles the overflow bit on every cycle of a test run. A stalled or stale capture stage then yields a value that differs from what the reference queue expects. Test runs of odd and even length are followed by re-entry, which shows whether the pattern phase restarts. The coding mode is changed while samples are in flight, so the bench can check that the coding is applied at the output latch.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
    parameter int unsigned CODE_W = 6;
    localparam int unsigned WORD_W = CODE_W + 1;
    localparam int unsigned LOW_W  = CODE_W - 1;

    typedef struct packed {
        logic              ovf;
        logic [CODE_W-1:0] code;
    } sample_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              rdy;
        logic              rdy_n;
    } out_state_t;

    typedef struct packed {
        logic active;
        logic next_p2;
    } test_state_t;

    // first pattern has ones on even bit positions (MSB of a 7-bit word is even)
    function automatic logic [WORD_W-1:0] alt_pattern(input logic second);
        logic [WORD_W-1:0] p;
        for (int i = 0; i < int'(WORD_W); i++) begin
            p[i] = ((i % 2) == 0) ^ second;
        end
        return p;
    endfunction
endpackage

// File: rtl/adc_fmt_capture.sv
module adc_fmt_capture
    import adc_fmt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sample_t samp_i,
    output sample_t samp_o
);
    sample_t samp_d, samp_q;

    always_comb begin
        samp_d = samp_q;
        if (rst) samp_d = '0;
        else     samp_d = samp_i;
    end

    always_ff @(posedge clk) begin
        samp_q <= samp_d;
    end

    assign samp_o = samp_q;

    // R10: capture keeps running regardless of any test mode
    p_capture_runs_r10: assert property (@(posedge clk) disable iff (rst)
        1 |=> samp_q == $past(samp_i));
endmodule

// File: rtl/adc_fmt_coder.sv
module adc_fmt_coder
    import adc_fmt_pkg::*;
(
    input  sample_t           samp_i,
    input  logic              msb_inv_i,
    input  logic              lsb_inv_i,
    output logic [WORD_W-1:0] word_o
);
    logic              top_bit;
    logic [LOW_W-1:0]  low_bits;

    always_comb begin
        top_bit  = samp_i.code[CODE_W-1] ^ msb_inv_i;
        low_bits = samp_i.code[LOW_W-1:0] ^ {LOW_W{lsb_inv_i}};
        word_o   = {samp_i.ovf, top_bit, low_bits};
    end
endmodule

// File: rtl/adc_fmt_testgen.sv
module adc_fmt_testgen
    import adc_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              test_i,
    output logic [WORD_W-1:0] pattern_o
);
    test_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        pattern_o = alt_pattern(1'b0);
        if (rst) begin
            st_d = '0;
        end else begin
            st_d.active = test_i;
            if (test_i && !st_q.active) begin
                pattern_o    = alt_pattern(1'b0);
                st_d.next_p2 = 1'b1;
            end else if (test_i) begin
                pattern_o    = alt_pattern(st_q.next_p2);
                st_d.next_p2 = !st_q.next_p2;
            end else begin
                st_d.next_p2 = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R12: every entry leaves the phase pointing at the second pattern
    p_phase_restart_r12: assert property (@(posedge clk) disable iff (rst)
        (test_i && !st_q.active) |=> st_q.next_p2);
endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt
    import adc_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_i,
    input  logic              ovf_i,
    input  logic              msb_inv_i,
    input  logic              lsb_inv_i,
    input  logic              test_i,
    output logic [WORD_W-1:0] data_o,
    output logic              dready_o,
    output logic              dready_n_o
);
    sample_t           raw_s, held_s;
    logic [WORD_W-1:0] coded_w, pat_w;
    logic              test_seen_q;
    out_state_t        out_d, out_q;

    assign raw_s = '{ovf: ovf_i, code: code_i};

    adc_fmt_capture i_capture (
        .clk    (clk),
        .rst    (rst),
        .samp_i (raw_s),
        .samp_o (held_s)
    );

    adc_fmt_coder i_coder (
        .samp_i    (held_s),
        .msb_inv_i (msb_inv_i),
        .lsb_inv_i (lsb_inv_i),
        .word_o    (coded_w)
    );

    adc_fmt_testgen i_testgen (
        .clk       (clk),
        .rst       (rst),
        .test_i    (test_i),
        .pattern_o (pat_w)
    );

    always_comb begin
        out_d = out_q;
        if (rst) begin
            out_d = '{word: '0, rdy: 1'b0, rdy_n: 1'b1};
        end else begin
            out_d.word  = test_i ? pat_w : coded_w;
            out_d.rdy   = !out_q.rdy;
            out_d.rdy_n = out_q.rdy;
        end
    end

    always_ff @(posedge clk) begin
        out_q       <= out_d;
        test_seen_q <= rst ? 1'b0 : test_i;
    end

    assign data_o     = out_q.word;
    assign dready_o   = out_q.rdy;
    assign dready_n_o = out_q.rdy_n;

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (data_o == '0 && !dready_o && dready_n_o));

    p_ready_toggle_r11: assert property (@(posedge clk) disable iff (rst)
        1 |=> dready_o != $past(dready_o));

    p_ready_compl_r11: assert property (@(posedge clk) disable iff (rst)
        1 |=> dready_n_o == !dready_o);

    p_entry_pat1_r8: assert property (@(posedge clk) disable iff (rst)
        (test_i && !test_seen_q) |=> data_o == alt_pattern(1'b0));

    p_alternate_r9: assert property (@(posedge clk) disable iff (rst)
        (test_i && test_seen_q) |=> data_o == ~$past(data_o));

    p_normal_data_r10: assert property (@(posedge clk) disable iff (rst)
        !test_i |=> data_o == $past(coded_w));

    p_ovf_pass_r7: assert property (@(posedge clk) disable iff (rst)
        !test_i |=> data_o[WORD_W-1] == $past(held_s.ovf));
endmodule

// File: tb/test_adc_out_fmt.sv
module test_adc_out_fmt;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] code_i = '0;
    logic       ovf_i = 1'b0, msb_inv_i = 1'b0, lsb_inv_i = 1'b0, test_i = 1'b0;
    logic [6:0] data_o;
    logic       dready_o, dready_n_o;

    int checks = 0, errors = 0, cycles = 0;
    logic [6:0] samp_q[$];
    logic [6:0] exp_data;
    logic       exp_rdy;
    int         run = 0, entries = 0;
    bit         was_test = 0, exit_now = 0;

    adc_out_fmt i_adc_out_fmt (
        .clk(clk), .rst(rst), .code_i(code_i), .ovf_i(ovf_i),
        .msb_inv_i(msb_inv_i), .lsb_inv_i(lsb_inv_i), .test_i(test_i),
        .data_o(data_o), .dready_o(dready_o), .dready_n_o(dready_n_o)
    );

    always #4 clk = ~clk;

    function automatic logic [6:0] fmt(logic [6:0] s, logic mi, logic li);
        logic [6:0] r = s;
        if (mi) r[5] = ~r[5];
        if (li) r[4:0] = ~r[4:0];
        return r;
    endfunction

    // reference model, updated at each rising edge from stable inputs
    always @(posedge clk) begin
        cycles++;
        exit_now = 0;
        if (rst) begin
            samp_q.delete();
            samp_q.push_back(7'd0);
            exp_data = '0; exp_rdy = 0; run = 0; was_test = 0;
        end else begin
            logic [6:0] held;
            held = samp_q.pop_front();
            samp_q.push_back({ovf_i, code_i});
            if (test_i) begin
                run++;
                if (run == 1) entries++;
                exp_data = (run % 2 == 1) ? 7'b1010101 : 7'b0101010;
            end else begin
                exit_now = was_test;
                run = 0;
                exp_data = fmt(held, msb_inv_i, lsb_inv_i);
            end
            was_test = test_i;
            exp_rdy = ~exp_rdy;
        end
    end

    task automatic chk(bit ok, string tag, logic [6:0] act, logic [6:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic compare();
        string tag;
        if (rst) begin
            chk(data_o == 0 && !dready_o && dready_n_o, "R1", {dready_o, dready_n_o, data_o[4:0]}, 7'b0100000);
            return;
        end
        if (run == 1 && entries > 1) tag = "R12";
        else if (run == 1) tag = "R8";
        else if (run > 1) tag = "R9";
        else if (exit_now) tag = "R10";
        else if (!msb_inv_i && !lsb_inv_i) tag = "R3 R2";
        else if (msb_inv_i && lsb_inv_i) tag = "R4 R2";
        else if (msb_inv_i) tag = "R5 R2";
        else tag = "R6 R2";
        chk(data_o === exp_data, tag, data_o, exp_data);
        if (run == 0) chk(data_o[6] === exp_data[6], "R7", {6'd0, data_o[6]}, {6'd0, exp_data[6]});
        chk(dready_o === exp_rdy && dready_n_o === ~exp_rdy, "R11",
            {5'd0, dready_o, dready_n_o}, {5'd0, exp_rdy, ~exp_rdy});
    endtask

    // one cycle: compare at falling edge, then drive next inputs
    task automatic step(logic [5:0] c, logic o, logic mi, logic li, logic t);
        @(negedge clk);
        compare();
        code_i = c; ovf_i = o; msb_inv_i = mi; lsb_inv_i = li; test_i = t;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare();
        rst = 1'b0;
        // four codings with corner codes
        for (int m = 0; m < 4; m++) begin
            step(6'd0, 1'b0, m[1], m[0], 1'b0);
            step(6'd32, 1'b1, m[1], m[0], 1'b0);
            step(6'd63, 1'b0, m[1], m[0], 1'b0);
            step(6'd31, 1'b1, m[1], m[0], 1'b0);
            for (int c = 0; c < 64; c += 7) step(6'(c), c[0], m[1], m[0], 1'b0);
        end
        // test run of odd length, ramp continues
        for (int k = 0; k < 5; k++) step(6'(40 + k), k[0], 1'b1, 1'b0, 1'b1);
        for (int k = 0; k < 4; k++) step(6'(10 + k), k[1], 1'b1, 1'b0, 1'b0);
        // even length then quick re-entries
        for (int k = 0; k < 4; k++) step(6'(50 + k), ~k[0], 1'b0, 1'b1, 1'b1);
        step(6'd3, 1'b1, 1'b0, 1'b1, 1'b0);
        for (int k = 0; k < 3; k++) step(6'(20 + k), k[0], 1'b1, 1'b1, 1'b1);
        step(6'd7, 1'b0, 1'b0, 1'b0, 1'b0);
        step(6'd9, 1'b1, 1'b0, 1'b0, 1'b1);
        step(6'd60, 1'b1, 1'b0, 1'b0, 1'b0);
        // coding changes while samples in flight
        for (int k = 0; k < 12; k++) step(6'(k * 5), k[1], k[0], k[2], 1'b0);
        // reset mid-run
        rst = 1'b1;
        step(6'd44, 1'b1, 1'b0, 1'b0, 1'b1);
        step(6'd44, 1'b1, 1'b0, 1'b0, 1'b1);
        rst = 1'b0;
        for (int k = 0; k < 3; k++) step(6'(k), 1'b0, 1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 3; k++) step(6'(k), 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        compare();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule